// File: doc/BRIEF.md
# Bit Clock Ratio Detector and PDM Clock Generator

This block works as a slave to an incoming serial-audio bit clock and frame clock. It oversamples both inputs on a free-running reference clock and counts bit-clock rising edges over each frame. It matches that count against six supported bit-clock-per-frame ratios (64, 128, 192, 256, 384 and 512). Once two frames in a row give the same supported ratio, it declares lock. It then divides the bit clock by 1, 2, 3, 4, 6 or 8, so the PDM microphone clock always runs at 64 times the frame rate. The divider counts bit-clock half-periods, so every divide factor, the odd factor 3 included, gives an exact 50% duty cycle in bit-clock half-periods.

The block also watches for loss of the bit clock. If no edge of either polarity arrives for a set number of reference cycles, it raises a power-down indication, drops lock and holds the PDM clock low. The indication clears on the next bit-clock edge. Lock is then measured again from scratch, and PDM clock generation restarts in phase with the frame-clock rising edge that grants lock.

Top module: `bclk_pdm_clkgen`

## Requirements
- R1: While `locked_o` is high, `ratio_o` reports the detected bit clocks per frame as 1=64, 2=128, 3=192, 4=256, 5=384, 6=512. While `locked_o` is low, `ratio_o` reads 0.
- R2: A measurement is the number of bit-clock rising edges between two consecutive frame-clock rising edges. Lock is granted on the frame-clock rising edge that closes the second consecutive frame with the same supported count. After reset or power-down, the first frame-clock rise seen once the bit clock is active only starts counting, so lock arrives at the fourth frame-clock rise.
- R3: A measurement that matches no supported ratio keeps `locked_o` low and `ratio_o` at 0, and `pdm_clk_o` stays low for the whole frame.
- R4: A supported measurement that differs from the previous one clears lock, and the PDM clock goes low. The next matching frame grants lock again with the new ratio.
- R5: While locked, `pdm_clk_o` has a period of N bit-clock periods and stays high for exactly N bit-clock half-periods, with N = ratio/64 (1, 2, 3, 4, 6 or 8).
- R6: While locked, exactly 64 PDM clock periods occur per frame for every supported ratio.
- R7: The first rising edge of `pdm_clk_o` after lock is granted comes N bit-clock half-periods after the frame-clock rising edge that granted lock. `pdm_clk_o` is low whenever `locked_o` is low.
- R8: If no bit-clock edge is seen for LOSS_CYCLES reference cycles, `pwrdn_o` rises, `locked_o` and `ratio_o` clear and `pdm_clk_o` is held low. `pwrdn_o` falls on the next bit-clock edge.
- R9: After reset, `pwrdn_o` is 1 and `locked_o`, `ratio_o` and `pdm_clk_o` are 0.
- R10: While frames keep measuring the locked ratio, `locked_o` stays high and `ratio_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Incoming serial bit clock |
| fclk_i | input | 1 | Incoming frame clock |
| pdm_clk_o | output | 1 | Generated PDM clock at 64x frame rate |
| locked_o | output | 1 | Ratio detected and PDM clock running |
| ratio_o | output | 3 | Detected ratio code (see R1) |
| pwrdn_o | output | 1 | Bit clock lost, block in power-down |

## Verification
Each input edge is seen through a two-stage synchronizer and reaches the outputs three reference cycles after it is driven. The bench therefore records the cycle at which it drives each frame-clock rise. It measures the lock-to-first-PDM-edge delay against N half-periods plus those three cycles, and it measures PDM high time and period as exact cycle counts. Lock is checked a few cycles after the fourth frame-clock rise, and the frame-change cases are checked one frame later. Power-down is checked 200 and 300 reference cycles after the last bit-clock edge, on either side of the 256-cycle loss window. All outputs are sampled on the falling reference edge, away from the edge that updates them.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
   localparam int NUM_CODES = 6;
   localparam int MAX_DIV   = 8;

   typedef logic [2:0] ratio_code_t;

   // divide factor of the bit clock for each ratio code
   function automatic int unsigned code_to_div(ratio_code_t c);
      case (c)
         3'd1:    return 1;
         3'd2:    return 2;
         3'd3:    return 3;
         3'd4:    return 4;
         3'd5:    return 6;
         3'd6:    return 8;
         default: return 0;
      endcase
   endfunction

   // match a measured bit-clock count against base * divide factor
   function automatic ratio_code_t count_to_code(int unsigned n, int unsigned base);
      ratio_code_t r;
      r = '0;
      for (int c = 1; c <= NUM_CODES; c++) begin
         if (n == base * code_to_div(ratio_code_t'(c))) r = ratio_code_t'(c);
      end
      return r;
   endfunction
endpackage

// File: rtl/bpc_sync_edge.sv
module bpc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic level_q
);
   logic [STAGES:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("bpc_sync_edge: STAGES must be at least 2");
   end

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign level   = chain[STAGES-1];
   assign level_q = chain[STAGES];
endmodule

// File: rtl/bpc_loss_watch.sv
module bpc_loss_watch #(
   parameter int LOSS_CYCLES = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic activity,
   output logic loss_hit,
   output logic lost
);
   localparam int W = $clog2(LOSS_CYCLES + 1);

   logic [W-1:0] idle;

   assign loss_hit = !activity && !lost && (idle == W'(LOSS_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle <= '0;
         lost <= 1'b1;
      end else if (activity) begin
         idle <= '0;
         lost <= 1'b0;
      end else if (!lost) begin
         if (loss_hit) begin
            idle <= '0;
            lost <= 1'b1;
         end else begin
            idle <= idle + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bpc_ratio_meter.sv
module bpc_ratio_meter
   import bpc_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int BASE  = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bclk_rise,
   input  logic        fclk_rise,
   input  logic        clear,
   output logic        locked,
   output logic        locked_nxt,
   output ratio_code_t code
);
   logic [CNT_W-1:0] cnt, cnt_d;
   logic             armed, armed_d;
   ratio_code_t      prev, prev_d, code_d, meas;

   assign meas = count_to_code(int'(cnt), BASE);

   always_comb begin
      cnt_d      = cnt;
      armed_d    = armed;
      prev_d     = prev;
      locked_nxt = locked;
      code_d     = code;
      if (clear) begin
         cnt_d      = '0;
         armed_d    = 1'b0;
         prev_d     = '0;
         locked_nxt = 1'b0;
         code_d     = '0;
      end else if (fclk_rise) begin
         cnt_d   = bclk_rise ? CNT_W'(1) : '0;
         armed_d = 1'b1;
         if (armed) begin
            if (meas == '0) begin
               locked_nxt = 1'b0;
               code_d     = '0;
               prev_d     = '0;
            end else if (meas == prev) begin
               locked_nxt = 1'b1;
               code_d     = meas;
            end else begin
               locked_nxt = 1'b0;
               code_d     = '0;
               prev_d     = meas;
            end
         end
      end else if (bclk_rise && cnt != '1) begin
         cnt_d = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         armed  <= 1'b0;
         prev   <= '0;
         locked <= 1'b0;
         code   <= '0;
      end else begin
         cnt    <= cnt_d;
         armed  <= armed_d;
         prev   <= prev_d;
         locked <= locked_nxt;
         code   <= code_d;
      end
   end
endmodule

// File: rtl/bpc_pdm_divider.sv
module bpc_pdm_divider #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start,
   input  logic             bclk_edge,
   input  logic [DIV_W-1:0] div,
   output logic             pdm
);
   logic [DIV_W-1:0] hcnt;
   logic             run;

   // toggle after every div bit-clock half-periods: 50% duty for any div
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         hcnt <= '0;
         pdm  <= 1'b0;
      end else if (!enable) begin
         run  <= 1'b0;
         hcnt <= '0;
         pdm  <= 1'b0;
      end else if (start) begin
         run  <= 1'b1;
         hcnt <= '0;
         pdm  <= 1'b0;
      end else if (run && bclk_edge) begin
         if (hcnt == div - 1'b1) begin
            hcnt <= '0;
            pdm  <= ~pdm;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bclk_pdm_clkgen.sv
module bclk_pdm_clkgen
   import bpc_pkg::*;
#(
   parameter int OVERSAMPLE  = 64,
   parameter int CNT_W       = 10,
   parameter int LOSS_CYCLES = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_ref,
   input  logic       rst_n,
   input  logic       bclk_i,
   input  logic       fclk_i,
   output logic       pdm_clk_o,
   output logic       locked_o,
   output logic [2:0] ratio_o,
   output logic       pwrdn_o
);
   localparam int DIV_W = $clog2(MAX_DIV + 1);

   if ((1 << CNT_W) <= MAX_DIV * OVERSAMPLE) begin : g_bad_cnt
      $error("bclk_pdm_clkgen: CNT_W too small for the largest ratio");
   end
   if (LOSS_CYCLES < 4) begin : g_bad_loss
      $error("bclk_pdm_clkgen: LOSS_CYCLES must be at least 4");
   end

   logic        bclk_s, bclk_sq, fclk_s, fclk_sq;
   logic        bclk_rise, bclk_any, fclk_rise;
   logic        loss_hit, lost, clear;
   logic        locked, locked_nxt;
   ratio_code_t code;
   logic [DIV_W-1:0] div;

   bpc_sync_edge #(.STAGES(SYNC_STAGES)) u_bclk_sync (
      .clk(clk_ref), .rst_n(rst_n), .din(bclk_i), .level(bclk_s), .level_q(bclk_sq)
   );
   bpc_sync_edge #(.STAGES(SYNC_STAGES)) u_fclk_sync (
      .clk(clk_ref), .rst_n(rst_n), .din(fclk_i), .level(fclk_s), .level_q(fclk_sq)
   );

   assign bclk_rise = bclk_s & ~bclk_sq;
   assign bclk_any  = bclk_s ^ bclk_sq;
   assign fclk_rise = fclk_s & ~fclk_sq;

   bpc_loss_watch #(.LOSS_CYCLES(LOSS_CYCLES)) u_loss (
      .clk(clk_ref), .rst_n(rst_n), .activity(bclk_any), .loss_hit(loss_hit), .lost(lost)
   );

   assign clear = loss_hit | lost;

   bpc_ratio_meter #(.CNT_W(CNT_W), .BASE(OVERSAMPLE)) u_meter (
      .clk(clk_ref), .rst_n(rst_n), .bclk_rise(bclk_rise), .fclk_rise(fclk_rise),
      .clear(clear), .locked(locked), .locked_nxt(locked_nxt), .code(code)
   );

   assign div = DIV_W'(code_to_div(code));

   bpc_pdm_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk_ref), .rst_n(rst_n), .enable(locked_nxt), .start(locked_nxt & ~locked),
      .bclk_edge(bclk_any), .div(div), .pdm(pdm_clk_o)
   );

   assign locked_o = locked;
   assign ratio_o  = locked ? code : '0;
   assign pwrdn_o  = lost;
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       locked,
   input logic [2:0] ratio,
   input logic       pdm,
   input logic       pwrdn,
   input logic       bclk_edge,
   input logic       fclk_rise
);
   AST_RATIO_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (ratio != 3'd0 && ratio <= 3'd6)); // R1
   AST_LOCK_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(fclk_rise)); // R2
   AST_PDM_RISE_ON_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdm) |-> $past(bclk_edge)); // R5
   AST_UNLOCKED_PDM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !pdm); // R7
   AST_PWRDN_CLEARS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn |-> !locked); // R8
   AST_PWRDN_PDM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn |-> !pdm); // R8
   AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked)) |-> $stable(ratio)); // R10
endmodule

bind bclk_pdm_clkgen bpc_checker u_chk (
   .clk(clk_ref), .rst_n(rst_n), .locked(locked_o), .ratio(ratio_o), .pdm(pdm_clk_o),
   .pwrdn(pwrdn_o), .bclk_edge(bclk_any), .fclk_rise(fclk_rise)
);

// File: tb/sim_bclk_pdm_clkgen.sv
module sim_bclk_pdm_clkgen;
   localparam int H    = 2;   // reference cycles per bit-clock half-period
   localparam int LAT  = 3;   // synchronizer + output register
   localparam int NV   = 7;
   localparam int VEC_RATIO [NV] = '{64, 128, 192, 256, 384, 512, 96};
   localparam int VEC_CODE  [NV] = '{1, 2, 3, 4, 5, 6, 0};
   localparam int VEC_DIV   [NV] = '{1, 2, 3, 4, 6, 8, 0};

   logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fclk = 1'b0;
   logic pdm, locked, pwrdn;
   logic [2:0] ratio;

   always #4 clk = ~clk;

   bclk_pdm_clkgen u0 (
      .clk_ref(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk),
      .pdm_clk_o(pdm), .locked_o(locked), .ratio_o(ratio), .pwrdn_o(pwrdn)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, errors = 0;
   bit done = 0;
   bit gen_on = 0, stopped = 0;
   int gen_ratio = 64, cur_ratio = 64, idx = 0;
   int frame_cnt = 0, rise_cyc = 0, stop_cyc = 0;

   // bit/frame clock source: frame clock changes with bit-clock falling edges
   initial begin
      forever begin
         @(negedge clk);
         if (!gen_on) begin
            if (!stopped) begin stop_cyc = cyc; stopped = 1; end
            bclk = 1'b0; fclk = 1'b0; idx = 0;
         end else begin
            stopped = 0;
            bclk = 1'b0;
            if (idx == 0) begin
               cur_ratio = gen_ratio; fclk = 1'b1; frame_cnt++; rise_cyc = cyc;
            end else if (idx == cur_ratio / 2) begin
               fclk = 1'b0;
            end
            repeat (H) @(negedge clk);
            bclk = 1'b1;
            idx = (idx + 1 == cur_ratio) ? 0 : idx + 1;
            repeat (H - 1) @(negedge clk);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic upto_frame(input int n);
      while (frame_cnt < n) @(negedge clk);
   endtask

   task automatic after_frame(input int n);
      upto_frame(n);
      repeat (8) @(negedge clk);
   endtask

   task automatic wait_pdm(input logic v, output int t);
      int k = 0;
      while (pdm !== v && k < 20000) begin @(negedge clk); k++; end
      t = cyc;
   endtask

   task automatic start_gen(input int r);
      frame_cnt = 0; gen_ratio = r; gen_on = 1;
   endtask

   task automatic stop_gen();
      gen_on = 0;
      repeat (400) @(negedge clk);
   endtask

   task automatic pdm_rises_in_frame(output int rises);
      int f;
      logic p;
      f = frame_cnt;
      while (frame_cnt == f) @(negedge clk);
      f = frame_cnt; p = pdm; rises = 0;
      while (frame_cnt == f) begin
         @(negedge clk);
         if (pdm && !p) rises++;
         p = pdm;
      end
   endtask

   always @(posedge clk) begin
      if (cyc == 150000 && !done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int t0, t1, t2, t3, n, rises;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", "pwrdn after reset", int'(pwrdn), 1);
      chk("R9", "locked after reset", int'(locked), 0);
      chk("R9", "ratio after reset", int'(ratio), 0);
      chk("R9", "pdm after reset", int'(pdm), 0);

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         n = VEC_DIV[v];
         start_gen(VEC_RATIO[v]);
         if (n != 0) begin
            upto_frame(4);
            t0 = rise_cyc;
            wait_pdm(1'b1, t1);
            chk("R7", "lock-to-first-pdm-rise delay", t1 - t0, n * H + LAT);
            wait_pdm(1'b0, t2);
            chk("R5", "pdm high time", t2 - t1, n * H);
            wait_pdm(1'b1, t3);
            chk("R5", "pdm period", t3 - t1, 2 * n * H);
            chk("R2", "locked", int'(locked), 1);
            chk("R1", "ratio code", int'(ratio), VEC_CODE[v]);
            chk("R8", "pwrdn while running", int'(pwrdn), 0);
            pdm_rises_in_frame(rises);
            chk("R6", "pdm periods per frame", rises, 64);
         end else begin
            after_frame(4);
            chk("R3", "locked on unsupported ratio", int'(locked), 0);
            chk("R3", "ratio on unsupported ratio", int'(ratio), 0);
            pdm_rises_in_frame(rises);
            chk("R3", "pdm rises on unsupported ratio", rises, 0);
            chk("R3", "pdm level on unsupported ratio", int'(pdm), 0);
         end
         stop_gen();
      end

      // R2: one measurement is not enough
      start_gen(192);
      after_frame(3);
      chk("R2", "locked after single measurement", int'(locked), 0);
      chk("R1", "ratio while unlocked", int'(ratio), 0);
      after_frame(4);
      chk("R2", "locked after two matching frames", int'(locked), 1);
      after_frame(5);
      chk("R10", "lock held", int'(locked), 1);
      chk("R10", "ratio held", int'(ratio), 3);
      gen_ratio = 384;   // takes effect on the frame starting at rise 6
      after_frame(6);
      chk("R10", "lock held before change measured", int'(locked), 1);
      chk("R10", "ratio before change measured", int'(ratio), 3);
      after_frame(7);
      chk("R4", "lock cleared on ratio change", int'(locked), 0);
      chk("R4", "pdm low on ratio change", int'(pdm), 0);
      after_frame(8);
      chk("R4", "relock after change", int'(locked), 1);
      chk("R4", "new ratio code", int'(ratio), 5);

      // R8 loss of bit clock
      gen_on = 0;
      while (!stopped) @(negedge clk);
      t0 = stop_cyc;
      while (cyc < t0 + 200) @(negedge clk);
      chk("R8", "pwrdn before loss window", int'(pwrdn), 0);
      chk("R8", "lock before loss window", int'(locked), 1);
      while (cyc < t0 + 300) @(negedge clk);
      chk("R8", "pwrdn after loss", int'(pwrdn), 1);
      chk("R8", "locked after loss", int'(locked), 0);
      chk("R8", "ratio after loss", int'(ratio), 0);
      chk("R8", "pdm after loss", int'(pdm), 0);
      start_gen(64);
      upto_frame(1);
      repeat (H + LAT + 2) @(negedge clk);
      chk("R8", "pwrdn cleared by bit-clock edge", int'(pwrdn), 0);
      after_frame(4);
      chk("R2", "relock after power-down", int'(locked), 1);
      chk("R1", "ratio after power-down relock", int'(ratio), 1);
      gen_on = 0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule